// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block produces the active-low control strobes for an external asynchronous static RAM whose 8-bit data pins are shared between reads and writes. A synchronous state machine steps through a fixed sequence of clock periods for each access. The strobes are registered, so every one of them is low for a whole number of clock periods inside a known window of the access. Write enable alone times a write. Chip enable follows the decoded access and is never the strobe that stores data. The data-bus drivers and output enable are kept apart by guard periods, so two sources never drive the shared bus at the same moment.

The block has two sources of requests. In bus mode a processor-side port gives a one-cycle request with direction, address and write data. In manual mode a raw push-button is synchronised, debounced and edge-detected. Each clean press writes the value on the data switches to the location on the address switches. A request that arrives while an access is in progress is dropped. The `busy` output tells the requester when it may try again.

Top module: `sram_seq`

## Requirements
- R1: After reset `ce_n`, `oe_n` and `we_n` are high, `drv_en` is low, `busy` is low and `rd_valid` is low.
- R2: An accepted write keeps `busy` high for exactly four clocks. `drv_en` is high in the first three. `we_n` is low only in the second. `sram_addr` and `sram_dout` carry the request's address and data for all four.
- R3: An accepted read keeps `busy` high for exactly three clocks. `oe_n` is low only in the second. In the third, `rd_valid` is high for one clock and `rd_data` holds the memory word seen at the end of the second.
- R4: `oe_n` stays high for the whole of every write, and `we_n` and `oe_n` are never low together.
- R5: `drv_en` is low in the clock before `oe_n` falls, while `oe_n` is low, and in the clock after `oe_n` returns high.
- R6: `ce_n` is low for every clock in which `busy` is high. It is already low in the clock before `we_n` falls and is still low when `we_n` returns high.
- R7: A request is taken only while `busy` is low. A request raised while `busy` is high is dropped and causes no memory access.
- R8: With `manual_mode` = 1, one debounced press of `btn_raw` produces exactly one write-enable pulse, storing `sw_data` at `sw_addr`. `req_valid` is ignored in this mode.
- R9: A level change on `btn_raw` that lasts fewer than 2^`DB_BITS` clocks produces no access.
- R10: With `manual_mode` = 0, `btn_raw` produces no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| manual_mode | input | 1 | 1 selects the button/switch source, 0 selects the processor port |
| req_valid | input | 1 | One-cycle processor request |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Processor address |
| req_wdata | input | DW | Processor write data |
| btn_raw | input | 1 | Raw push-button level, active high |
| sw_addr | input | AW | Switch-set address |
| sw_data | input | DW | Switch-set data |
| sram_addr | output | AW | Address to the memory |
| sram_dout | output | DW | Data toward the bus drivers |
| sram_din | input | DW | Data read from the memory pins |
| ce_n | output | 1 | Chip enable, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| drv_en | output | 1 | Enable of the tri-state data drivers |
| busy | output | 1 | Access in progress |
| rd_data | output | DW | Captured read word |
| rd_valid | output | 1 | One-cycle flag that `rd_data` is new |

## Verification
Seeded random mixes of reads and writes over a small address window run back to back. They reveal whether read data follows earlier writes and whether each access keeps its exact strobe shape when the next request comes the cycle after `busy` drops. A request injected during a write tells a sequencer that drops requests apart from one that queues or restarts. Button patterns separate a clean long press (one store), a level that chatters faster than the debounce window (no store), a press in bus mode (no store) and a processor request in manual mode (no store).

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WSETUP,
      ST_WPULSE,
      ST_WHOLD,
      ST_WREL,
      ST_RGUARD,
      ST_ROE,
      ST_RPOST
   } seq_state_t;

   typedef struct packed {
      logic ce_n;
      logic oe_n;
      logic we_n;
      logic drv_en;
      logic busy;
   } strobe_t;

   function automatic strobe_t strobe_of(seq_state_t s);
      strobe_t r;
      r = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv_en: 1'b0, busy: 1'b0};
      case (s)
         ST_WSETUP, ST_WHOLD: begin r.ce_n = 1'b0; r.drv_en = 1'b1; r.busy = 1'b1; end
         ST_WPULSE: begin r.ce_n = 1'b0; r.drv_en = 1'b1; r.we_n = 1'b0; r.busy = 1'b1; end
         ST_WREL, ST_RGUARD, ST_RPOST: begin r.ce_n = 1'b0; r.busy = 1'b1; end
         ST_ROE: begin r.ce_n = 1'b0; r.oe_n = 1'b0; r.busy = 1'b1; end
         default: ;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/sram_btn_cond.sv
module sram_btn_cond #(
   parameter int SYNC_STAGES = 2,
   parameter int DB_BITS     = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic btn_raw,
   output logic press_pulse
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic [DB_BITS-1:0]     cnt_q;
   logic                   stable_q;
   logic                   stable_d1_q;
   logic                   btn_s;

   generate
      genvar gi;
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sync_q[gi] <= 1'b0;
            else if (gi == 0)
               sync_q[gi] <= btn_raw;
            else
               sync_q[gi] <= sync_q[(gi > 0) ? gi-1 : 0];
         end
      end
   endgenerate

   assign btn_s = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q       <= '0;
         stable_q    <= 1'b0;
         stable_d1_q <= 1'b0;
      end else begin
         stable_d1_q <= stable_q;
         if (btn_s == stable_q)
            cnt_q <= '0;
         else if (&cnt_q) begin
            cnt_q    <= '0;
            stable_q <= btn_s;
         end else
            cnt_q <= cnt_q + 1'b1;
      end
   end

   assign press_pulse = stable_q & ~stable_d1_q;

   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      press_pulse |=> !press_pulse);

endmodule

// File: rtl/sram_strobe_fsm.sv
module sram_strobe_fsm
   import sram_seq_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          start_write,
   input  logic [AW-1:0] start_addr,
   input  logic [DW-1:0] start_wdata,
   input  logic [DW-1:0] sram_din,
   output logic [AW-1:0] sram_addr,
   output logic [DW-1:0] sram_dout,
   output logic          ce_n,
   output logic          oe_n,
   output logic          we_n,
   output logic          drv_en,
   output logic          busy,
   output logic [DW-1:0] rd_data,
   output logic          rd_valid
);
   seq_state_t st_q, st_d;
   strobe_t    stb_q;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:   if (start) st_d = start_write ? ST_WSETUP : ST_RGUARD;
         ST_WSETUP: st_d = ST_WPULSE;
         ST_WPULSE: st_d = ST_WHOLD;
         ST_WHOLD:  st_d = ST_WREL;
         ST_RGUARD: st_d = ST_ROE;
         ST_ROE:    st_d = ST_RPOST;
         default:   st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         stb_q     <= strobe_of(ST_IDLE);
         sram_addr <= '0;
         sram_dout <= '0;
         rd_data   <= '0;
         rd_valid  <= 1'b0;
      end else begin
         st_q     <= st_d;
         stb_q    <= strobe_of(st_d);
         rd_valid <= (st_d == ST_RPOST);
         if (st_q == ST_IDLE && start) begin
            sram_addr <= start_addr;
            sram_dout <= start_wdata;
         end
         if (st_q == ST_ROE)
            rd_data <= sram_din;
      end
   end

   assign ce_n   = stb_q.ce_n;
   assign oe_n   = stb_q.oe_n;
   assign we_n   = stb_q.we_n;
   assign drv_en = stb_q.drv_en;
   assign busy   = stb_q.busy;

   a_r4_no_we_oe_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !oe_n));
   a_r5_drv_off_before_oe: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> (!drv_en && !$past(drv_en)));
   a_r5_drv_off_after_oe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_n) |-> !drv_en);
   a_r2_we_single_clock: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |=> we_n);
   a_r2_bus_stable_on_we: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> (drv_en && $stable(sram_addr) && $stable(sram_dout)));
   a_r6_ce_before_we: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> $past(!ce_n));
   a_r6_ce_after_we: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> !ce_n);
   a_r7_addr_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(sram_addr));
   a_r3_valid_after_oe: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ($rose(oe_n) && busy));

endmodule

// File: rtl/sram_seq.sv
module sram_seq #(
   parameter int AW          = 8,
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2,
   parameter int DB_BITS     = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          manual_mode,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          btn_raw,
   input  logic [AW-1:0] sw_addr,
   input  logic [DW-1:0] sw_data,
   output logic [AW-1:0] sram_addr,
   output logic [DW-1:0] sram_dout,
   input  logic [DW-1:0] sram_din,
   output logic          ce_n,
   output logic          oe_n,
   output logic          we_n,
   output logic          drv_en,
   output logic          busy,
   output logic [DW-1:0] rd_data,
   output logic          rd_valid
);
   generate
      if (AW < 1 || DW < 1)      $error("sram_seq: AW and DW must be positive");
      if (SYNC_STAGES < 2)       $error("sram_seq: at least two sync stages");
      if (DB_BITS < 1 || DB_BITS > 24) $error("sram_seq: DB_BITS out of range");
   endgenerate

   logic          press;
   logic          start;
   logic          start_write;
   logic [AW-1:0] start_addr;
   logic [DW-1:0] start_wdata;

   sram_btn_cond #(
      .SYNC_STAGES (SYNC_STAGES),
      .DB_BITS     (DB_BITS)
   ) i_btn (
      .clk         (clk),
      .rst_n       (rst_n),
      .btn_raw     (btn_raw),
      .press_pulse (press)
   );

   always_comb begin
      if (manual_mode) begin
         start       = press;
         start_write = 1'b1;
         start_addr  = sw_addr;
         start_wdata = sw_data;
      end else begin
         start       = req_valid;
         start_write = req_write;
         start_addr  = req_addr;
         start_wdata = req_wdata;
      end
   end

   sram_strobe_fsm #(
      .AW (AW),
      .DW (DW)
   ) i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .start_write (start_write),
      .start_addr  (start_addr),
      .start_wdata (start_wdata),
      .sram_din    (sram_din),
      .sram_addr   (sram_addr),
      .sram_dout   (sram_dout),
      .ce_n        (ce_n),
      .oe_n        (oe_n),
      .we_n        (we_n),
      .drv_en      (drv_en),
      .busy        (busy),
      .rd_data     (rd_data),
      .rd_valid    (rd_valid)
   );

   a_r7_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$past(we_n)) |=> busy);

endmodule

// File: tb/test_sram_seq.sv
module test_sram_seq;
   localparam int AW = 8;
   localparam int DW = 8;
   localparam int DB = 3;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          manual_mode = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          btn_raw = 1'b0;
   logic [AW-1:0] sw_addr = '0;
   logic [DW-1:0] sw_data = '0;
   logic [AW-1:0] sram_addr;
   logic [DW-1:0] sram_dout;
   logic [DW-1:0] sram_din;
   logic          ce_n, oe_n, we_n, drv_en, busy, rd_valid;
   logic [DW-1:0] rd_data;

   logic [DW-1:0] mem     [DEPTH];
   logic [DW-1:0] exp_mem [DEPTH];
   int n_checks = 0;
   int n_fail   = 0;
   int we_falls = 0;
   logic we_prev = 1'b1;

   always #10 clk = ~clk;

   sram_seq #(.AW(AW), .DW(DW), .SYNC_STAGES(2), .DB_BITS(DB)) i_sram_seq (
      .clk(clk), .rst_n(rst_n), .manual_mode(manual_mode),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .btn_raw(btn_raw), .sw_addr(sw_addr),
      .sw_data(sw_data), .sram_addr(sram_addr), .sram_dout(sram_dout),
      .sram_din(sram_din), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .drv_en(drv_en), .busy(busy), .rd_data(rd_data), .rd_valid(rd_valid)
   );

   // behavioural memory
   assign sram_din = (!oe_n && !ce_n) ? mem[sram_addr] : '0;
   always @(posedge we_n) if (!ce_n && drv_en) mem[sram_addr] <= sram_dout;

   always @(negedge clk) begin
      if (we_prev && !we_n) we_falls++;
      we_prev <= we_n;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic strobes(input string req, input bit e_busy, input bit e_ce_n,
                          input bit e_oe_n, input bit e_we_n, input bit e_drv);
      chk({busy, ce_n, oe_n, we_n, drv_en} == {e_busy, e_ce_n, e_oe_n, e_we_n, e_drv},
          req, {busy, ce_n, oe_n, we_n, drv_en}, {e_busy, e_ce_n, e_oe_n, e_we_n, e_drv});
   endtask

   // bus write; inject=1 raises a second request during the pulse clock
   task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit inject);
      req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
      @(negedge clk); req_valid = 0;
      strobes("R2 setup", 1, 0, 1, 1, 1);
      chk(sram_addr == a && sram_dout == d, "R2 addr/data", {sram_addr, sram_dout}, {a, d});
      if (inject) begin
         req_valid = 1; req_write = 1; req_addr = a ^ 8'h80; req_wdata = ~d;
      end
      @(negedge clk); req_valid = 0;
      strobes("R2 pulse", 1, 0, 1, 0, 1);
      @(negedge clk);
      strobes("R2 hold", 1, 0, 1, 1, 1);
      chk(sram_addr == a && sram_dout == d, "R2 held", {sram_addr, sram_dout}, {a, d});
      @(negedge clk);
      strobes("R2 release", 1, 0, 1, 1, 0);
      @(negedge clk);
      strobes("R2 idle", 0, 1, 1, 1, 0);
      exp_mem[a] = d;
   endtask

   task automatic bus_read(input logic [AW-1:0] a);
      req_valid = 1; req_write = 0; req_addr = a;
      @(negedge clk); req_valid = 0;
      strobes("R5 guard", 1, 0, 1, 1, 0);
      @(negedge clk);
      strobes("R3 oe", 1, 0, 0, 1, 0);
      @(negedge clk);
      strobes("R5 post", 1, 0, 1, 1, 0);
      chk(rd_valid == 1, "R3 rd_valid", rd_valid, 1);
      chk(rd_data == exp_mem[a], "R3 rd_data", rd_data, exp_mem[a]);
      @(negedge clk);
      strobes("R3 idle", 0, 1, 1, 1, 0);
      chk(rd_valid == 0, "R3 valid one clock", rd_valid, 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      int seed;
      int w0;
      seed = 32'h5EED;
      void'($urandom(seed));
      for (int i = 0; i < DEPTH; i++) begin mem[i] = '0; exp_mem[i] = '0; end
      repeat (3) @(negedge clk);
      strobes("R1 reset", 0, 1, 1, 1, 0);
      chk(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
      rst_n = 1;
      @(negedge clk);
      strobes("R1 after reset", 0, 1, 1, 1, 0);

      // directed write/read, then R7 inject during busy
      bus_write(8'h12, 8'hA5, 0);
      bus_read(8'h12);
      w0 = we_falls;
      bus_write(8'h05, 8'h3C, 1);
      repeat (2) @(negedge clk);
      chk(we_falls - w0 == 1, "R7 busy request dropped", we_falls - w0, 1);
      bus_read(8'h85);
      bus_read(8'h05);

      // random mix, back to back
      for (int i = 0; i < 40; i++) begin
         logic [AW-1:0] a;
         a = AW'($urandom_range(0, 15));
         if ($urandom_range(0, 1) == 1) bus_write(a, DW'($urandom), 0);
         else bus_read(a);
      end

      // R10 button ignored in bus mode
      w0 = we_falls;
      sw_addr = 8'h40; sw_data = 8'h77;
      btn_raw = 1; repeat (30) @(negedge clk);
      btn_raw = 0; repeat (30) @(negedge clk);
      chk(we_falls == w0, "R10 button in bus mode", we_falls - w0, 0);
      bus_read(8'h40);

      // R8 manual press
      manual_mode = 1;
      sw_addr = 8'h41; sw_data = 8'hC3;
      w0 = we_falls;
      btn_raw = 1; repeat (30) @(negedge clk);
      btn_raw = 0; repeat (30) @(negedge clk);
      chk(we_falls - w0 == 1, "R8 one pulse per press", we_falls - w0, 1);
      exp_mem[8'h41] = 8'hC3;

      // R9 chatter shorter than window
      w0 = we_falls;
      sw_addr = 8'h42; sw_data = 8'h99;
      for (int k = 0; k < 8; k++) begin
         btn_raw = ~btn_raw; repeat (3) @(negedge clk);
      end
      btn_raw = 0; repeat (30) @(negedge clk);
      chk(we_falls == w0, "R9 chatter ignored", we_falls - w0, 0);

      // R8 processor request ignored in manual mode
      req_valid = 1; req_write = 1; req_addr = 8'h43; req_wdata = 8'h11;
      @(negedge clk); req_valid = 0;
      repeat (6) @(negedge clk);
      chk(we_falls == w0, "R8 request ignored in manual", we_falls - w0, 0);

      manual_mode = 0;
      @(negedge clk);
      bus_read(8'h41);
      bus_read(8'h42);
      bus_read(8'h43);

      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule